// File: doc/BRIEF.md
# Encoder-Driven Timer Counter

This block is a bounded up/down counter for motor-position and event-counting work. It is fed by two encoder lines and by an internal trigger. A small register port selects the counting source and direction, enables counting, loads the count and sets the upper bound. In the two single-line modes, one encoder line clocks the counter and the level of the other line sets the direction. In quadrature mode, both lines are decoded together, so every edge is one count and one full encoder cycle gives four counts. Two modes run from the block clock. One counts freely. The other is also reloaded by a rising edge on the trigger input.

The count always stays between zero and the active bound. Counting up past the bound returns the count to zero. Counting down past zero returns it to the bound. Each wrap raises a one-cycle update pulse. The bound can be buffered so that a new value takes effect only at the next update. The encoder lines are synchronised before edge detection, so they may be asynchronous to the clock.

Register map: address 0 is control (bit 0 run, bit 4 direction with 1 meaning down, bit 7 bound buffering). Address 1 is the mode in bits 2:0. Address 2 is the count. Address 3 is the bound. Reads return the selected register with all unused bits zero.

Top module: `enc_timer`

## Requirements
- R1: After reset the count is 0, the bound reads all ones, control and mode read 0, the direction output is 0 and the update output is low.
- R2: While control bit 0 is clear, the count does not change except through a write to address 2. Encoder edges and clock cycles have no effect.
- R3: In mode 1, each synchronised rising edge of line A is one count. The count goes down when line B is high and up when it is low. Edges on line B do not count.
- R4: In mode 2, each synchronised rising edge of line B is one count. The count goes down when line A is high and up when it is low. Edges on line A do not count.
- R5: In mode 3, every single-line change is one count. Transitions 00→10→11→01→00 (written as A,B) count up and the reverse order counts down. A change of both lines at once is not counted.
- R6: When a count step up occurs at the active bound, the count becomes 0 and the update output is high for exactly that following cycle.
- R7: When a count step down occurs at 0, the count becomes the active bound and the update output is high for that following cycle.
- R8: With control bit 7 clear, a write to address 3 changes the active bound at once. With it set, the written value reads back at address 3 but becomes active only at the next update event.
- R9: A write to address 2 loads the count on that clock edge and takes priority over counting.
- R10: In modes 0 and 4, the direction comes from control bit 4 as written. In modes 1 to 3, bit 4 and the direction output follow the direction of the latest encoder count.
- R11: In mode 0, the count steps once per clock. Mode 4 does the same, and in addition a rising edge on the trigger input reloads the count (to 0 when counting up, to the bound when counting down) and raises the update output. The trigger is ignored in every other mode.
- R12: Modes 5 to 7 do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| trig_in | input | 1 | Internal trigger, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr, combinational |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | Current direction, 1 = down |
| upd_o | output | 1 | One-cycle update event |

## Verification
The hardest case to reach is a bound change under buffering while the count is running. The new bound has to sit unused through one wrap at the old bound and then govern the next wrap. The bench programs a short bound, enables buffering, writes a longer bound while the counter is stopped, and then lets the internal clock run across two wraps while a reference model swaps bounds at the first update. The quadrature case where both lines flip together is reached by driving both lines in the same cycle, so they cross the synchroniser together.

// File: rtl/enc_timer_pkg.sv
// Package: shared constants for the encoder timer.
// Assumes a 2-bit register address space; control bit positions are fixed.
package enc_timer_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_PRE  = 2'd3;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_DIR_BIT  = 4;
    localparam int CTRL_ARPE_BIT = 7;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MD_INTCLK  = 3'd0;
    localparam logic [MODE_W-1:0] MD_A_CNT   = 3'd1;
    localparam logic [MODE_W-1:0] MD_B_CNT   = 3'd2;
    localparam logic [MODE_W-1:0] MD_QUAD    = 3'd3;
    localparam logic [MODE_W-1:0] MD_TRIG_RST = 3'd4;
endpackage

// File: rtl/enc_sync.sv
// Module: multi-flop synchroniser for a bundle of asynchronous lines.
// Assumes each line is independently slow relative to clk (no bus coherence).
module enc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw lines through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/enc_decode.sv
// Module: edge detector and count/direction decoder for two encoder lines.
// Assumes inputs are already synchronised; produces a count request and a
// direction for modes 1..3 only, nothing for other modes.
module enc_decode
    import enc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a,
    input  logic              b,
    input  logic [MODE_W-1:0] mode,
    output logic              step,
    output logic              down
);
    logic a_q, b_q;
    logic a_rise, b_rise, a_chg, b_chg;

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a;
            b_q <= b;
        end
    end

    assign a_rise = a & ~a_q;
    assign b_rise = b & ~b_q;
    assign a_chg  = a ^ a_q;
    assign b_chg  = b ^ b_q;

    // Pick count source and direction according to the mode.
    always_comb begin
        step = 1'b0;
        down = 1'b0;
        case (mode)
            MD_A_CNT: begin
                step = a_rise;
                down = b;
            end
            MD_B_CNT: begin
                step = b_rise;
                down = a;
            end
            MD_QUAD: begin
                step = a_chg ^ b_chg;
                down = ~(a ^ b_q);
            end
            default: begin
                step = 1'b0;
                down = 1'b0;
            end
        endcase
    end

    AST_STEP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (a != a_q) || (b != b_q)); // R5
endmodule

// File: rtl/enc_core.sv
// Module: bounded up/down counter with buffered bound and update pulse.
// Assumes at most one of software load, reload or step matters per cycle,
// in that priority order.
module enc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             down,
    input  logic             reload,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic             pre_we,
    input  logic [CNT_W-1:0] pre_wval,
    input  logic             arpe,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] preset_act,
    output logic [CNT_W-1:0] preset_buf,
    output logic             upd
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_top, at_bot, wrap, evt;

    assign at_top = (cnt == preset_act);
    assign at_bot = (cnt == '0);
    assign wrap   = step & (down ? at_bot : at_top);
    assign evt    = ~cnt_we & (reload | wrap);

    // Advance, wrap, reload or load the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_we) begin
            cnt <= cnt_wval;
        end else if (reload) begin
            cnt <= down ? preset_act : '0;
        end else if (step) begin
            if (down) begin
                cnt <= at_bot ? preset_act : cnt - 1'b1;
            end else begin
                cnt <= at_top ? '0 : cnt + 1'b1;
            end
        end
    end

    // Register the update event as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd <= 1'b0;
        end else begin
            upd <= evt;
        end
    end

    // Maintain written bound and the bound in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset_buf <= CNT_MAX;
            preset_act <= CNT_MAX;
        end else begin
            if (pre_we) begin
                preset_buf <= pre_wval;
            end
            if (arpe && evt) begin
                preset_act <= preset_buf;
            end else if (!arpe && pre_we) begin
                preset_act <= pre_wval;
            end
        end
    end

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !down && !cnt_we && !reload && cnt == preset_act) |=> (cnt == '0) && upd); // R6
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && down && !cnt_we && !reload && cnt == '0) |=> (cnt == $past(preset_act)) && upd); // R7
    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arpe && !evt) |=> $stable(preset_act)); // R8
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt == $past(cnt_wval))); // R9
endmodule

// File: rtl/enc_timer.sv
// Module: top of the encoder timer; register port, mode routing, trigger edge.
// Assumes trig_in is synchronous to clk; encoder lines may be asynchronous.
module enc_timer
    import enc_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              trig_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_o,
    output logic              upd_o
);
    logic              run_q, dir_q, arpe_q, trig_q;
    logic [MODE_W-1:0] mode_q;
    logic [1:0]        ab_s;
    logic              dec_step, dec_down;
    logic              wr_ctrl, wr_mode, wr_cnt, wr_pre;
    logic              enc_mode, int_mode;
    logic              core_step, core_down, core_reload;
    logic [CNT_W-1:0]  preset_act, preset_buf;

    assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_mode = reg_we && (reg_addr == ADDR_MODE);
    assign wr_cnt  = reg_we && (reg_addr == ADDR_CNT);
    assign wr_pre  = reg_we && (reg_addr == ADDR_PRE);

    enc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({enc_a, enc_b}),
        .q     (ab_s)
    );

    enc_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (ab_s[1]),
        .b     (ab_s[0]),
        .mode  (mode_q),
        .step  (dec_step),
        .down  (dec_down)
    );

    assign enc_mode    = (mode_q == MD_A_CNT) || (mode_q == MD_B_CNT) || (mode_q == MD_QUAD);
    assign int_mode    = (mode_q == MD_INTCLK) || (mode_q == MD_TRIG_RST);
    assign core_step   = run_q && (enc_mode ? dec_step : int_mode);
    assign core_down   = enc_mode ? dec_down : dir_q;
    assign core_reload = run_q && (mode_q == MD_TRIG_RST) && trig_in && !trig_q;

    // Control and mode registers; direction also tracks encoder counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            dir_q  <= 1'b0;
            arpe_q <= 1'b0;
            mode_q <= MD_INTCLK;
        end else begin
            if (wr_ctrl) begin
                run_q  <= reg_wdata[CTRL_RUN_BIT];
                dir_q  <= reg_wdata[CTRL_DIR_BIT];
                arpe_q <= reg_wdata[CTRL_ARPE_BIT];
            end else if (run_q && enc_mode && dec_step) begin
                dir_q <= dec_down;
            end
            if (wr_mode) begin
                mode_q <= reg_wdata[MODE_W-1:0];
            end
        end
    end

    // Previous trigger level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_in;
        end
    end

    enc_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (core_step),
        .down       (core_down),
        .reload     (core_reload),
        .cnt_we     (wr_cnt),
        .cnt_wval   (reg_wdata),
        .pre_we     (wr_pre),
        .pre_wval   (reg_wdata),
        .arpe       (arpe_q),
        .cnt        (cnt_o),
        .preset_act (preset_act),
        .preset_buf (preset_buf),
        .upd        (upd_o)
    );

    assign dir_o = dir_q;

    // Read mux for the register port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_RUN_BIT]  = run_q;
                reg_rdata[CTRL_DIR_BIT]  = dir_q;
                reg_rdata[CTRL_ARPE_BIT] = arpe_q;
            end
            ADDR_MODE: reg_rdata[MODE_W-1:0] = mode_q;
            ADDR_CNT:  reg_rdata = cnt_o;
            default:   reg_rdata = preset_buf;
        endcase
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_cnt) |=> $stable(cnt_o)); // R2
    AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q > MD_TRIG_RST && !wr_cnt) |=> $stable(cnt_o)); // R12
    AST_TRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && mode_q == MD_TRIG_RST && trig_in && !trig_q && !wr_cnt) |=> upd_o); // R11
    AST_DIR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && enc_mode && dec_step && !wr_ctrl) |=> (dir_o == $past(dec_down))); // R10
endmodule

// File: tb/enc_timer_tb.sv
`timescale 1ns/1ps
module enc_timer_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enc_a = 1'b0, enc_b = 1'b0, trig_in = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata, cnt_o;
    logic             dir_o, upd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    enc_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .trig_in(trig_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic enc(logic a, logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [CNT_W-1:0] v;
        chk("R1 cnt", cnt_o, 0);
        chk("R1 upd", upd_o, 0);
        chk("R1 dir", dir_o, 0);
        rd(3, v); chk("R1 bound", v, 16'hFFFF);
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 mode", v, 0);
    endtask

    task automatic t_disable();
        wr(0, 0); wr(1, 0); wr(3, 100); wr(2, 7);
        repeat (5) @(negedge clk);
        chk("R2 clock ignored", cnt_o, 7);
        wr(1, 1);
        enc(1, 0); enc(0, 0);
        chk("R2 encoder ignored", cnt_o, 7);
    endtask

    task automatic t_wrap_up();
        int exp;
        logic eu;
        wr(0, 0); wr(1, 0); wr(3, 3); wr(2, 0); wr(0, 1);
        exp = 0;
        chk("R8 immediate bound start", cnt_o, 0);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            eu = (exp == 3);
            exp = (exp == 3) ? 0 : exp + 1;
            chk("R6 up count", cnt_o, exp);
            chk("R6 up pulse", upd_o, eu);
        end
        wr(0, 0);
    endtask

    task automatic t_wrap_down();
        int exp;
        logic eu;
        logic [CNT_W-1:0] v;
        wr(3, 5); wr(2, 2); wr(0, 16'h11);
        chk("R10 dir out", dir_o, 1);
        exp = 2;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            eu = (exp == 0);
            exp = (exp == 0) ? 5 : exp - 1;
            chk("R7 down count", cnt_o, exp);
            chk("R7 down pulse", upd_o, eu);
        end
        wr(0, 16'h10);
        rd(0, v); chk("R10 dir readback", v[4], 1);
        wr(0, 0);
    endtask

    task automatic t_preload();
        int exp, bound;
        logic eu;
        logic [CNT_W-1:0] v;
        wr(0, 0); wr(1, 0); wr(3, 3); wr(2, 0);
        wr(0, 16'h80); wr(3, 6);
        rd(3, v); chk("R8 buffered readback", v, 6);
        wr(0, 16'h81);
        exp = 0; bound = 3;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            eu = (exp == bound);
            if (exp == bound) begin
                exp = 0; bound = 6;
            end else begin
                exp = exp + 1;
            end
            chk("R8 buffered count", cnt_o, exp);
            chk("R8 buffered pulse", upd_o, eu);
        end
        wr(0, 0);
    endtask

    task automatic t_cnt_write();
        wr(1, 0); wr(3, 100); wr(2, 0); wr(0, 1);
        repeat (3) @(negedge clk);
        wr(2, 40);
        chk("R9 load", cnt_o, 40);
        @(negedge clk);
        chk("R9 after load", cnt_o, 41);
        wr(0, 0);
    endtask

    task automatic t_mode_a();
        logic [CNT_W-1:0] v;
        enc(0, 0);
        wr(1, 1); wr(3, 100); wr(2, 10); wr(0, 1);
        enc(1, 0); chk("R3 A rise up", cnt_o, 11);
        enc(0, 0); chk("R3 A fall", cnt_o, 11);
        enc(1, 0); chk("R3 A rise up 2", cnt_o, 12);
        enc(0, 1); chk("R3 B edge ignored", cnt_o, 12);
        enc(1, 1); chk("R3 A rise down", cnt_o, 11);
        rd(0, v); chk("R10 encoder dir", v[4], 1);
        enc(0, 0);
        wr(0, 0);
    endtask

    task automatic t_mode_b();
        wr(1, 2); wr(2, 10); wr(0, 1);
        enc(0, 1); chk("R4 B rise up", cnt_o, 11);
        enc(0, 0); enc(1, 0); chk("R4 A edge ignored", cnt_o, 11);
        enc(1, 1); chk("R4 B rise down", cnt_o, 10);
        enc(0, 0);
        wr(0, 0);
    endtask

    task automatic t_quad();
        enc(0, 0);
        wr(1, 3); wr(2, 50); wr(0, 1);
        enc(1, 0); chk("R5 first edge", cnt_o, 51);
        enc(1, 1); enc(0, 1); enc(0, 0);
        chk("R5 four up", cnt_o, 54);
        chk("R10 quad dir up", dir_o, 0);
        enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
        chk("R5 four down", cnt_o, 50);
        chk("R10 quad dir down", dir_o, 1);
        enc(1, 1); chk("R5 double flip", cnt_o, 50);
        enc(0, 0); chk("R5 double flip back", cnt_o, 50);
        wr(0, 0);
    endtask

    task automatic t_trig();
        logic [CNT_W-1:0] c;
        wr(1, 4); wr(3, 100); wr(2, 20); wr(0, 1);
        repeat (3) @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        chk("R11 reload up", cnt_o, 0);
        chk("R11 reload pulse", upd_o, 1);
        @(negedge clk);
        chk("R11 level no reload", cnt_o, 1);
        chk("R11 pulse ends", upd_o, 0);
        trig_in = 1'b0;
        wr(0, 16'h11);
        trig_in = 1'b1;
        @(negedge clk);
        chk("R11 reload down", cnt_o, 100);
        chk("R11 reload down pulse", upd_o, 1);
        trig_in = 1'b0;
        wr(1, 0);
        @(negedge clk);
        c = cnt_o;
        trig_in = 1'b1;
        @(negedge clk);
        chk("R11 ignored in mode 0", cnt_o, c - 1);
        chk("R11 no pulse in mode 0", upd_o, 0);
        trig_in = 1'b0;
        wr(0, 0);
    endtask

    task automatic t_idle_mode();
        wr(1, 5); wr(2, 33); wr(0, 1);
        repeat (4) @(negedge clk);
        chk("R12 mode 5 idle", cnt_o, 33);
        wr(1, 7);
        repeat (4) @(negedge clk);
        chk("R12 mode 7 idle", cnt_o, 33);
        wr(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disable();
        t_wrap_up();
        t_wrap_down();
        t_preload();
        t_cnt_write();
        t_mode_a();
        t_mode_b();
        t_quad();
        t_trig();
        t_idle_mode();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule